// File: doc/BRIEF.md
# Programmable wake-up phase sequencer

Once configuration has finished, this block brings a device out of configuration in a fixed, selectable order. It runs four phases, T0 to T3, one clock cycle each, and releases four global controls: the DONE indicator, the global output enable, the release of the global write disable and the release of the global set/reset. Each control is tied to one phase, and several controls may share a phase. Once released, a control stays released.

A 5-bit selector picks one of 25 numbered orderings. The block computes the ordering table from a formula and holds it as a parameter. A mode input sets the start condition. With the mode low, the sequence starts when the internal done bit is seen, whatever the level of the external DONE pin. With the mode high, the sequence also waits for the external DONE pin to be seen high, after that pin has passed through a two-flop synchronizer. A synchronous restart input returns the block to its waiting state.

Top module: `wake_seq`

## Requirements
- R1: During and right after the active-low reset `rst_ni`, all five outputs are low.
- R2: With `wait_pin_i`=0, the block takes `done_bit_i`=1 at a rising clock edge as the start condition, even when `done_pin_i` is low. Phase T0 is then visible in the cycle after that edge, and T1, T2 and T3 follow in the next three cycles.
- R3: With `wait_pin_i`=1, the block also needs `done_pin_i` high. That pin passes through two flops, so the start is taken at the third rising edge after the pin goes high. While the pin stays low, nothing is released.
- R4: Sequence s has index k = s-1. The release phases are: DONE in phase k mod 4, output enable in phase (k/4) mod 4, write-disable release in phase (k/16) mod 4, and set/reset release in phase 3-(k mod 4). A control is high in every phase at or after its own phase.
- R5: Selector values 1 to 25 pick sequence s = `seq_sel_i`. The values 0 and 26 to 31 pick sequence 21.
- R6: A released output stays high until `cfg_restart_i` is asserted.
- R7: `wake_done_o` rises in the cycle after T3, with all four controls high, and stays high until a restart.
- R8: `cfg_restart_i`=1 at a clock edge drives all outputs low in the following cycle, and the block goes back to waiting for the start condition.
- R9: The selector is latched at the start. Changing it during the sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_restart_i | input | 1 | Synchronous return to the waiting state; clears all releases |
| done_bit_i | input | 1 | Internal done bit from configuration |
| done_pin_i | input | 1 | External DONE pin level (asynchronous) |
| wait_pin_i | input | 1 | 1 = also wait for the external DONE pin |
| seq_sel_i | input | 5 | Wake-up sequence number |
| done_o | output | 1 | DONE indicator released |
| oe_rel_o | output | 1 | Global output enable released |
| wr_rel_o | output | 1 | Global write disable released |
| sr_rel_o | output | 1 | Global set/reset released |
| wake_done_o | output | 1 | Wake-up finished |

## Verification
Once the start condition is seen at a clock edge, the outputs for phase p are due p+1 edges later, and `wake_done_o` is due five edges later. The bench drives inputs on falling edges and samples once in each of those five half-cycles. With the external pin gating, the start takes two more edges for the synchronizer, so the bench checks that the outputs are still low one edge before they are due and set on time. A restart is checked in the half-cycle right after the edge that captured it.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned NUM_SEQ = 25;
  localparam int unsigned DEF_SEQ = 21;
  localparam int unsigned PH_W    = 2;
  localparam int unsigned NUM_SIG = 4;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned WORD_W  = NUM_SIG * PH_W;

  typedef logic [WORD_W-1:0] seq_word_t;
  typedef logic [NUM_SEQ-1:0][WORD_W-1:0] seq_tbl_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CMPL} st_e;

  // field order: [1:0] done, [3:2] oe, [5:4] wr, [7:6] sr
  function automatic seq_word_t seq_entry(int unsigned k);
    seq_word_t w;
    w[1:0] = PH_W'(k % 4);
    w[3:2] = PH_W'((k / 4) % 4);
    w[5:4] = PH_W'((k / 16) % 4);
    w[7:6] = PH_W'(3 - (k % 4));
    return w;
  endfunction

  function automatic seq_tbl_t build_tbl();
    seq_tbl_t t;
    for (int unsigned i = 0; i < NUM_SEQ; i++) t[i] = seq_entry(i);
    return t;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wake_seq_lookup.sv
module wake_seq_lookup
  import wake_pkg::*;
#(
  parameter int unsigned    N_SEQ = NUM_SEQ,
  parameter int unsigned    D_SEQ = DEF_SEQ,
  parameter seq_tbl_t       TBL   = build_tbl()
) (
  input  logic [SEL_W-1:0] sel_i,
  output seq_word_t        word_o
);
  logic                 in_range;
  logic [SEL_W-1:0]     idx;

  assign in_range = (sel_i != '0) && (int'(sel_i) <= int'(N_SEQ));
  assign idx      = in_range ? sel_i - SEL_W'(1) : SEL_W'(D_SEQ - 1);
  assign word_o   = TBL[idx];
endmodule

// File: rtl/wake_phase_fsm.sv
module wake_phase_fsm
  import wake_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               start_i,
  input  seq_word_t          word_i,
  output logic [NUM_SIG-1:0] rel_o,
  output logic               cmpl_o,
  output logic               busy_o
);
  st_e             st_q;
  logic [PH_W-1:0] ph_q;
  seq_word_t       word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      word_q <= '0;
    end else if (restart_i) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          ph_q   <= '0;
          word_q <= word_i;  // selector latched at start
        end
        ST_RUN: begin
          if (ph_q == '1) st_q <= ST_CMPL;
          else            ph_q <= ph_q + PH_W'(1);
        end
        default: st_q <= ST_CMPL;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_rel
    assign rel_o[g] = (st_q == ST_CMPL) ||
                      ((st_q == ST_RUN) && (word_q[g*PH_W +: PH_W] <= ph_q));
  end

  assign cmpl_o = (st_q == ST_CMPL);
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_restart_i,
  input  logic             done_bit_i,
  input  logic             done_pin_i,
  input  logic             wait_pin_i,
  input  logic [SEL_W-1:0] seq_sel_i,
  output logic             done_o,
  output logic             oe_rel_o,
  output logic             wr_rel_o,
  output logic             sr_rel_o,
  output logic             wake_done_o
);
  logic               pin_q;
  logic               start;
  logic               busy;
  seq_word_t          word;
  logic [NUM_SIG-1:0] rel;

  wake_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (done_pin_i),
    .q_o   (pin_q)
  );

  wake_seq_lookup u_lut (
    .sel_i (seq_sel_i),
    .word_o(word)
  );

  assign start = done_bit_i & (~wait_pin_i | pin_q);

  wake_phase_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_restart_i),
    .start_i  (start),
    .word_i   (word),
    .rel_o    (rel),
    .cmpl_o   (wake_done_o),
    .busy_o   (busy)
  );

  assign done_o   = rel[0];
  assign oe_rel_o = rel[1];
  assign wr_rel_o = rel[2];
  assign sr_rel_o = rel[3];
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_restart_i,
  input logic done_bit_i,
  input logic wait_pin_i,
  input logic pin_q,
  input logic busy,
  input logic done_o,
  input logic oe_rel_o,
  input logic wr_rel_o,
  input logic sr_rel_o,
  input logic wake_done_o
);
  logic [3:0] rel;
  assign rel = {sr_rel_o, wr_rel_o, oe_rel_o, done_o};

  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |=> (rel == '0 && !wake_done_o));

  a_r2_start_needs_done_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(done_bit_i));

  a_r3_start_needs_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && $past(wait_pin_i)) |-> $past(pin_q));

  a_r6_release_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rel != '0) && !cfg_restart_i) |=> ((rel & $past(rel)) == $past(rel)));

  a_r7_complete_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> (rel == 4'hF));

  a_r7_after_t3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_done_o) |-> ($past(rel) == 4'hF && $past(busy)));

  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_restart_i |=> (rel == '0 && !wake_done_o));
endmodule

bind wake_seq wake_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_restart_i(cfg_restart_i),
  .done_bit_i   (done_bit_i),
  .wait_pin_i   (wait_pin_i),
  .pin_q        (pin_q),
  .busy         (busy),
  .done_o       (done_o),
  .oe_rel_o     (oe_rel_o),
  .wr_rel_o     (wr_rel_o),
  .sr_rel_o     (sr_rel_o),
  .wake_done_o  (wake_done_o)
);

// File: tb/sim_wake_seq.sv
`timescale 1ns/1ps
module sim_wake_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       restart = 1'b0, done_bit = 1'b0, done_pin = 1'b0, wait_pin = 1'b0;
  logic [4:0] sel = 5'd0;
  logic       done_o, oe_o, wr_o, sr_o, wake_o;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wake_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_restart_i(restart), .done_bit_i(done_bit),
    .done_pin_i(done_pin), .wait_pin_i(wait_pin), .seq_sel_i(sel),
    .done_o(done_o), .oe_rel_o(oe_o), .wr_rel_o(wr_o), .sr_rel_o(sr_o), .wake_done_o(wake_o)
  );

  typedef struct packed { logic [4:0] s; logic w; } vec_t;
  localparam vec_t VEC [12] = '{
    '{5'd1, 1'b0}, '{5'd4, 1'b0}, '{5'd7, 1'b0}, '{5'd13, 1'b0},
    '{5'd17, 1'b1}, '{5'd21, 1'b0}, '{5'd25, 1'b0}, '{5'd0, 1'b0},
    '{5'd26, 1'b1}, '{5'd31, 1'b0}, '{5'd10, 1'b1}, '{5'd22, 1'b0}};

  // R5: out-of-range selects sequence 21
  function automatic int kidx(logic [4:0] s);
    return (s >= 1 && s <= 25) ? int'(s) - 1 : 20;
  endfunction

  // R4: expected {sr,wr,oe,done} in phase p (p=4 -> wake done, all high)
  function automatic logic [4:0] expv(int k, int p);
    int ph [4];
    logic [4:0] v;
    ph[0] = k % 4; ph[1] = (k / 4) % 4; ph[2] = (k / 16) % 4; ph[3] = 3 - (k % 4);
    v[4] = (p >= 4);
    for (int i = 0; i < 4; i++) v[i] = (ph[i] <= p);
    return v;
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {wake_o, sr_o, wr_o, oe_o, done_o};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 5'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", 5'b0);

    // vector walk: R2 (pin low, immediate), R4 phases, R5 fallback, R7, R9
    foreach (VEC[i]) begin
      int k;
      k = kidx(VEC[i].s);
      restart = 1'b1; done_bit = 1'b0;
      @(negedge clk);
      restart = 1'b0;
      sel = VEC[i].s; wait_pin = VEC[i].w; done_pin = VEC[i].w;
      repeat (3) @(negedge clk);
      done_bit = 1'b1;
      for (int p = 0; p < 5; p++) begin
        @(negedge clk);
        sel = ~sel;  // R9: ignored after start
        chk(p < 4 ? "R4" : "R7", expv(k, p));
      end
      repeat (3) @(negedge clk);
      chk("R6", 5'h1F);
    end

    // R8: restart clears
    restart = 1'b1;
    @(negedge clk);
    chk("R8", 5'b0);
    restart = 1'b0; done_bit = 1'b0;

    // R3: wait for external pin (seq 1: DONE in T0)
    sel = 5'd1; wait_pin = 1'b1; done_pin = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0; done_bit = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3", 5'b0);
    done_pin = 1'b1;
    @(negedge clk);
    chk("R3", 5'b0);
    @(negedge clk);
    chk("R3", 5'b0);
    @(negedge clk);
    chk("R3", expv(0, 0));

    // R2: pin low ignored in immediate mode
    restart = 1'b1; done_bit = 1'b0;
    @(negedge clk);
    restart = 1'b0; wait_pin = 1'b0; done_pin = 1'b0; sel = 5'd1;
    @(negedge clk);
    chk("R2", 5'b0);
    done_bit = 1'b1;
    @(negedge clk);
    chk("R2", expv(0, 0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule